// File: doc/BRIEF.md
# Luma Setup Brightness Adder

This block sits in the luma path of a standard-definition video encoder, after luma scaling. It takes each scaled luma sample and adds a signed setup (pedestal) offset that comes from a brightness register. The offset is added only when the feature is enabled and the sample lies in active video. Blanking and sync samples, and every sample while the feature is off, leave the block unchanged.

The offset is a 7-bit two's complement number held in the low seven bits of an 8-bit register. Its scale is about 2.0156 luma codes per IRE, so +20 IRE is code 0x28 and -7 IRE is code 0x72. Before the offset is used, it is limited to the window that the selected video mode allows. With pedestal the window is 0 to +22.5 IRE. Without pedestal, and for PAL, it is -7.5 to +15 IRE. The sum is saturated to the legal luma code range. A status output flags register codes that are known to give an unusable signal.

Top module: `luma_setup_adder`

## Requirements
- R1: The setup offset is `bright_reg[6:0]` read as 7-bit two's complement (0x72 means -14, 0x28 means +40, 0x71 means -15). `bright_reg[7]` has no effect on the luma output or on the flag.
- R2: When `bright_en` is 0, a valid sample comes out equal to its input, with no change and no clipping.
- R3: When `active_in` is 0, a valid sample comes out equal to its input, even if `bright_en` is 1.
- R4: With `mode_flat` = 0 (with pedestal), the offset is limited to the range 0 to +45 codes (0 to +22.5 IRE) before it is added.
- R5: With `mode_flat` = 1 (without pedestal, or PAL), the offset is limited to the range -15 to +30 codes (-7.5 to +15 IRE) before it is added.
- R6: An adjusted sample is saturated to the range 4 to 1019 and never wraps around.
- R7: `code_invalid` is 1 exactly when `bright_reg[6:0]` lies in 0x3F to 0x44 inclusive. It follows the register combinationally.
- R8: `y_out` and `y_valid_out` are registered, with one cycle of latency from `y_in` and `y_valid_in`. While reset is held, both are 0. A cycle with `y_valid_in` = 0 gives `y_valid_out` = 0 one cycle later.
- R9: When the offset is inside the window of the mode, it is added exactly (for example, 200 + 0x28 with pedestal gives 240, and 200 + 0x72 without pedestal gives 186).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| y_in | input | 10 | Scaled luma sample |
| y_valid_in | input | 1 | High when `y_in` carries a sample |
| active_in | input | 1 | High during active video |
| bright_reg | input | 8 | Brightness register; bits [6:0] hold the signed offset |
| bright_en | input | 1 | Enables the setup adder |
| mode_flat | input | 1 | 0: NTSC with pedestal; 1: NTSC without pedestal or PAL |
| y_out | output | 10 | Adjusted luma sample |
| y_valid_out | output | 1 | Valid strobe for `y_out` |
| code_invalid | output | 1 | High when the register code is in the unusable band |

## Verification
The bench targets the sign boundary of the 7-bit field. A design that read the field as unsigned would turn 0x72 into a large positive offset, and a design that used bit 7 would change the output when only that bit toggles. It drives codes past each edge of both mode windows. A missing or swapped clamp would then add 62 or 40 codes where 45 or 30 are due, or subtract where the pedestal mode allows no negative offset. It pushes sums past both ends of the luma range, where a non-saturating adder wraps. It also walks the flag across 0x3E to 0x45, where an off-by-one band or a signed compare misses the edges.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  typedef enum logic {
    MODE_PEDESTAL = 1'b0,
    MODE_FLAT     = 1'b1
  } lsa_mode_e;

  // limit a signed value into [lo, hi]
  function automatic logic signed [7:0] clamp_s8(input logic signed [7:0] v,
                                                 input logic signed [7:0] lo,
                                                 input logic signed [7:0] hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/lsa_setup_decode.sv
module lsa_setup_decode
  import lsa_pkg::*;
#(
  parameter int CODE_W  = 7,
  parameter int PED_LO  = 0,
  parameter int PED_HI  = 45,
  parameter int FLAT_LO = -15,
  parameter int FLAT_HI = 30,
  parameter int BAD_LO  = 'h3F,
  parameter int BAD_HI  = 'h44
) (
  input  logic [CODE_W-1:0]        code_i,
  input  lsa_mode_e                mode_i,
  output logic signed [CODE_W-1:0] setup_o,
  output logic                     bad_o
);

  localparam logic signed [7:0] PED_LO_S  = 8'(PED_LO);
  localparam logic signed [7:0] PED_HI_S  = 8'(PED_HI);
  localparam logic signed [7:0] FLAT_LO_S = 8'(FLAT_LO);
  localparam logic signed [7:0] FLAT_HI_S = 8'(FLAT_HI);
  localparam logic [CODE_W-1:0] BAD_LO_U  = CODE_W'(BAD_LO);
  localparam logic [CODE_W-1:0] BAD_HI_U  = CODE_W'(BAD_HI);

  logic signed [CODE_W-1:0] raw_s;
  logic signed [7:0]        raw_w;
  logic signed [7:0]        lim_w;

  assign raw_s = $signed(code_i);
  assign raw_w = 8'(raw_s);

  always_comb begin
    if (mode_i == MODE_PEDESTAL) lim_w = clamp_s8(raw_w, PED_LO_S, PED_HI_S);
    else                         lim_w = clamp_s8(raw_w, FLAT_LO_S, FLAT_HI_S);
  end

  assign setup_o = lim_w[CODE_W-1:0];
  // band is contiguous in the unsigned view of the raw code
  assign bad_o   = (code_i >= BAD_LO_U) && (code_i <= BAD_HI_U);

endmodule

// File: rtl/lsa_sat_add.sv
module lsa_sat_add #(
  parameter int LUMA_W  = 10,
  parameter int CODE_W  = 7,
  parameter int LUMA_LO = 4,
  parameter int LUMA_HI = 1019
) (
  input  logic [LUMA_W-1:0]        y_i,
  input  logic signed [CODE_W-1:0] setup_i,
  output logic [LUMA_W-1:0]        y_o,
  output logic                     hit_hi_o,
  output logic                     hit_lo_o
);

  localparam int SW = LUMA_W + 2;
  localparam logic signed [SW-1:0] HI_S = SW'(LUMA_HI);
  localparam logic signed [SW-1:0] LO_S = SW'(LUMA_LO);

  logic signed [SW-1:0] wide;

  assign wide     = $signed({2'b00, y_i}) + SW'(setup_i);
  assign hit_hi_o = wide > HI_S;
  assign hit_lo_o = wide < LO_S;

  always_comb begin
    if (hit_hi_o)      y_o = HI_S[LUMA_W-1:0];
    else if (hit_lo_o) y_o = LO_S[LUMA_W-1:0];
    else               y_o = wide[LUMA_W-1:0];
  end

endmodule

// File: rtl/luma_setup_adder.sv
module luma_setup_adder
  import lsa_pkg::*;
#(
  parameter int LUMA_W  = 10,
  parameter int LUMA_LO = 4,
  parameter int LUMA_HI = 1019,
  parameter int PED_LO  = 0,
  parameter int PED_HI  = 45,
  parameter int FLAT_LO = -15,
  parameter int FLAT_HI = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LUMA_W-1:0] y_in,
  input  logic              y_valid_in,
  input  logic              active_in,
  input  logic [7:0]        bright_reg,
  input  logic              bright_en,
  input  logic              mode_flat,
  output logic [LUMA_W-1:0] y_out,
  output logic              y_valid_out,
  output logic              code_invalid
);

  localparam int CODE_W = 7;
  localparam logic signed [CODE_W-1:0] PED_LO_C  = CODE_W'(PED_LO);
  localparam logic signed [CODE_W-1:0] PED_HI_C  = CODE_W'(PED_HI);
  localparam logic signed [CODE_W-1:0] FLAT_LO_C = CODE_W'(FLAT_LO);
  localparam logic signed [CODE_W-1:0] FLAT_HI_C = CODE_W'(FLAT_HI);

  lsa_mode_e                mode_w;
  logic signed [CODE_W-1:0] setup_w;
  logic [LUMA_W-1:0]        summed_w;
  logic                     hit_hi_w, hit_lo_w;
  logic                     apply_w;

  assign mode_w  = lsa_mode_e'(mode_flat);
  assign apply_w = bright_en && active_in;

  lsa_setup_decode #(
    .CODE_W (CODE_W),
    .PED_LO (PED_LO), .PED_HI (PED_HI),
    .FLAT_LO(FLAT_LO), .FLAT_HI(FLAT_HI)
  ) u_decode (
    .code_i (bright_reg[CODE_W-1:0]),
    .mode_i (mode_w),
    .setup_o(setup_w),
    .bad_o  (code_invalid)
  );

  lsa_sat_add #(
    .LUMA_W(LUMA_W), .CODE_W(CODE_W),
    .LUMA_LO(LUMA_LO), .LUMA_HI(LUMA_HI)
  ) u_add (
    .y_i     (y_in),
    .setup_i (setup_w),
    .y_o     (summed_w),
    .hit_hi_o(hit_hi_w),
    .hit_lo_o(hit_lo_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_out       <= '0;
      y_valid_out <= 1'b0;
    end else begin
      y_valid_out <= y_valid_in;
      if (y_valid_in) y_out <= apply_w ? summed_w : y_in;
    end
  end

  // ---------------- assertions ----------------
  assert_valid_pipe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid_in |=> y_valid_out);
  assert_valid_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !y_valid_in |=> !y_valid_out);
  assert_bypass_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (y_valid_in && !bright_en) |=> (y_out == $past(y_in)));
  assert_bypass_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (y_valid_in && !active_in) |=> (y_out == $past(y_in)));
  assert_ped_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_flat |-> (setup_w >= PED_LO_C && setup_w <= PED_HI_C));
  assert_flat_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_flat |-> (setup_w >= FLAT_LO_C && setup_w <= FLAT_HI_C));
  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (y_valid_in && apply_w) |=> (y_out >= LUMA_W'(LUMA_LO) && y_out <= LUMA_W'(LUMA_HI)));
  assert_sat_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_hi_w && hit_lo_w));
  assert_flag_band_R7: assert property (@(posedge clk) disable iff (!rst_n)
    code_invalid |-> (bright_reg[6] ? (bright_reg[5:0] <= 6'd4) : (bright_reg[5:0] == 6'h3F)));
  assert_top_bit_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((bright_reg[7] != $past(bright_reg[7])) && $stable(bright_reg[6:0]) && $stable(mode_flat))
      |-> $stable(setup_w));

endmodule

// File: tb/luma_setup_adder_tb_top.sv
module luma_setup_adder_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] y_in = '0;
  logic       y_valid_in = 1'b0;
  logic       active_in = 1'b0;
  logic [7:0] bright_reg = '0;
  logic       bright_en = 1'b0;
  logic       mode_flat = 1'b0;
  logic [9:0] y_out;
  logic       y_valid_out;
  logic       code_invalid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    int    y;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  luma_setup_adder dut_i (
    .clk(clk), .rst_n(rst_n), .y_in(y_in), .y_valid_in(y_valid_in),
    .active_in(active_in), .bright_reg(bright_reg), .bright_en(bright_en),
    .mode_flat(mode_flat), .y_out(y_out), .y_valid_out(y_valid_out),
    .code_invalid(code_invalid)
  );

  // reference model, written from the requirements
  function automatic int model(int y, bit act, int rv, bit en, bit flat);
    int off, lo, hi, s;
    off = rv % 128;
    if (off > 63) off = off - 128;
    if (flat) begin lo = -15; hi = 30; end
    else      begin lo = 0;   hi = 45; end
    if (off < lo) off = lo;
    if (off > hi) off = hi;
    if (!(en && act)) return y;
    s = y + off;
    if (s > 1019) s = 1019;
    if (s < 4) s = 4;
    return s;
  endfunction

  task automatic check(bit ok, string tag, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  task automatic drive(int y, bit act, int rv, bit en, bit flat, bit vld, string tag);
    @(negedge clk);
    y_in = 10'(y); active_in = act; bright_reg = 8'(rv);
    bright_en = en; mode_flat = flat; y_valid_in = vld;
    if (vld) sb.push_back('{model(y, act, rv, en, flat), tag});
  endtask

  task automatic flag_check(int rv, bit expv);
    @(negedge clk);
    y_valid_in = 1'b0;
    bright_reg = 8'(rv);
    #1;
    check(code_invalid == expv, "R7 code_invalid", int'(code_invalid), int'(expv));
  endtask

  // monitor: pops the scoreboard as results emerge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (y_valid_out) begin
        if (sb.size() == 0) begin
          check(1'b0, "R8 unexpected y_valid_out", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(int'(y_out) == e.y, e.tag, int'(y_out), e.y);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(y_out == 10'd0, "R8 reset y_out", int'(y_out), 0);
    check(y_valid_out == 1'b0, "R8 reset y_valid_out", int'(y_valid_out), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R9 exact addition inside the window
    drive(200, 1, 'h28, 1, 0, 1, "R9 ped +40");
    drive(200, 1, 'h72, 1, 1, 1, "R9 flat -14");
    // R1 top bit ignored, sign of field
    drive(200, 1, 'hA8, 1, 0, 1, "R1 bit7 set");
    drive(200, 1, 'hF2, 1, 1, 1, "R1 bit7 set negative");
    // R2 / R3 bypass
    drive(200, 1, 'h28, 0, 0, 1, "R2 disabled");
    drive(2,   1, 'h71, 0, 1, 1, "R2 disabled no clip");
    drive(200, 0, 'h28, 1, 0, 1, "R3 blanking");
    drive(1021, 0, 'h1E, 1, 1, 1, "R3 sync no clip");
    // R8 gap then back-to-back burst
    drive(300, 1, 'h00, 1, 0, 0, "R8 gap");
    drive(300, 1, 'h00, 1, 0, 0, "R8 gap");
    // R4 pedestal window
    drive(200, 1, 'h3E, 1, 0, 1, "R4 clamp high");
    drive(200, 1, 'h71, 1, 0, 1, "R4 clamp negative to 0");
    drive(200, 1, 'h2D, 1, 0, 1, "R4 edge 45");
    // R5 flat window
    drive(200, 1, 'h28, 1, 1, 1, "R5 clamp high");
    drive(200, 1, 'h60, 1, 1, 1, "R5 clamp low");
    drive(200, 1, 'h1E, 1, 1, 1, "R5 edge +30");
    drive(200, 1, 'h71, 1, 1, 1, "R5 edge -15");
    drive(200, 1, 'h0F, 1, 1, 1, "R5 +7.5 IRE");
    // R6 saturation
    drive(1010, 1, 'h2D, 1, 0, 1, "R6 saturate high");
    drive(10,   1, 'h71, 1, 1, 1, "R6 saturate low");
    drive(1019, 1, 'h00, 1, 0, 1, "R6 at top");
    drive(500, 1, 'h00, 1, 0, 0, "R8 tail");
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R8 all results delivered", sb.size(), 0);

    // R7 flag band, with R1 top bit
    flag_check('h3E, 1'b0);
    flag_check('h3F, 1'b1);
    flag_check('h40, 1'b1);
    flag_check('h44, 1'b1);
    flag_check('h45, 1'b0);
    flag_check('hBF, 1'b1);
    flag_check('hC5, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule